// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is a down-counting interval timer with a configurable counter width (24 bits by default). Software fills a preload value one byte at a time, picks a count source and an output behaviour in a control byte, and then sets the run bit. From then on the counter steps down once per tick. A tick comes from the system clock, from a synchronized external input, or from either of these divided by 32. When the count arrives at zero, a sticky zero flag is raised. On the next tick the counter either reloads the preload value or wraps to all ones, depending on the control byte.

The single output pin has two uses. In interrupt mode it mirrors the zero flag and stays high until software clears that flag. In square-wave mode it flips at every zero arrival. The external input has two uses as well. It can be a clock, in which case each synchronized rising edge is one tick. It can also be a level gate, in which case system-clock ticks only count while the synchronized input is high. Periodic interrupts, square waves, time-out-and-measure, elapsed time and pulse counting are all built from these controls.

The register port carries no data stream. Every write is taken in the cycle it is presented, and a read returns data combinationally from the read address. No back-pressure exists on either side.

Top module: `dcnt_timer`

## Requirements
- R1: After reset, every register reads zero, the zero flag is clear and `tout` is low.
- R2: Preload bytes are written and read back at address 2 (most significant byte), address 3 (middle byte) and address 4 (least significant byte). The live count reads back in the same byte order at addresses 5, 6 and 7. The control byte is at address 0 and the status byte is at address 1.
- R3: Control bit 0 is run. The cycle after run goes from 0 to 1, the counter holds the preload value, and no decrement happens in that cycle.
- R4: While running, each tick lowers a nonzero count by one. With control bit 3 clear, a tick at zero reloads the preload value, so zero is reached every preload+1 ticks.
- R5: With control bit 3 set, a tick at zero wraps the count to all ones, and counting continues from there.
- R6: Status bit 0 is the zero flag. It is set in the cycle the count arrives at zero. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. When an arrival at zero and a clear happen in the same cycle, the flag stays set.
- R7: With control bit 4 clear (interrupt mode), `tout` is high exactly while the zero flag is set.
- R8: With control bit 4 set (square-wave mode), `tout` changes level in each cycle in which the count arrives at zero.
- R9: With control bit 2 set, only every 32nd source tick after run starts reaches the counter.
- R10: With control bit 1 set, the tick source is the rising edges of `ext_in`. These edges are seen through a two-stage synchronizer, so an edge counts in the second cycle after it is captured.
- R11: With control bit 1 clear and control bit 5 set, system-clock ticks are counted only while the synchronized `ext_in` is high.
- R12: While run is 0, the count does not change, whatever happens on `ext_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken at the clock edge |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| ext_in | input | 1 | External count clock or gate, asynchronous |
| tout | output | 1 | Interrupt request or square wave |

## Verification
The assertions check the counter's step rules on every cycle:
- a load follows the start of run;
- a tick decrements, reloads or wraps as selected;
- a halted count holds;
- the zero flag obeys its set and write-one-to-clear rules;
- `tout` rises or flips on each zero arrival.

Only the bench's scenarios can show the exact periods:
- the preload+1 period in reload mode;
- the 32-cycle spacing of prescaled ticks;
- the synchronizer delay on external edges;
- the number of ticks a gate window lets through.

These are checked by predicting the cycle of every `tout` change and by reading back the count after the timer is halted.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  // control byte layout, bit 0 first from the right
  typedef struct packed {
    logic [1:0] spare;
    logic       gate;     // bit 5: count system ticks only while input high
    logic       square;   // bit 4: square-wave output
    logic       roll;     // bit 3: wrap to all ones instead of reload
    logic       presc;    // bit 2: divide ticks by 32
    logic       src_ext;  // bit 1: tick on external rising edges
    logic       run;      // bit 0: run/halt
  } ctrl_t;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_PRE  = 2;

endpackage

// File: rtl/dcnt_sync.sv
module dcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/dcnt_presc.sv
module dcnt_presc #(
  parameter int DIV_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bypass,
  input  logic tick_in,
  output logic tick_out
);
  logic [DIV_W-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (clear)   pc <= '0;
    else if (tick_in) pc <= pc + 1'b1;
  end

  assign tick_out = bypass ? tick_in : (tick_in & (pc == '1));
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             roll,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             zero_evt
);
  logic load, step, at_zero, at_one;

  assign load    = run & ~armed;
  assign step    = run & armed & tick;
  assign at_zero = (count == '0);
  assign at_one  = (count == CNT_W'(1));
  // arrival at zero: decrement from one, or reload of a zero preload
  assign zero_evt = step & (at_one | (at_zero & ~roll & (preload == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      count <= '0;
    end else begin
      armed <= run;
      if (load)
        count <= preload;
      else if (step) begin
        if (at_zero) count <= roll ? '1 : preload;
        else         count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int DIV_W   = 5,
  parameter int SYNC_ST = 2,
  localparam int NB     = CNT_W / 8,
  localparam int ADDR_W = $clog2(2 + 2 * NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              ext_in,
  output logic              tout
);
  localparam int CNT_BASE = A_PRE + NB;

  ctrl_t            ctrl_q;
  logic [7:0]       pre_q [NB];
  logic [CNT_W-1:0] pre_val;
  logic [CNT_W-1:0] cnt_val;
  logic             zds_q, sq_q;
  logic             ext_lvl, ext_rise, tick_raw, step_tick;
  logic             armed, zero_evt;
  logic             run_en, roll_en, sq_mode;
  logic             stat_clr;

  assign run_en  = ctrl_q.run;
  assign roll_en = ctrl_q.roll;
  assign sq_mode = ctrl_q.square;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(wr_data);
  end

  for (genvar i = 0; i < NB; i++) begin : g_pre
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_PRE + NB - 1 - i)) pre_q[i] <= wr_data;
    end
    assign pre_val[8*i +: 8] = pre_q[i];
  end

  dcnt_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in), .level(ext_lvl), .rise(ext_rise)
  );

  always_comb begin
    if (ctrl_q.src_ext)   tick_raw = ext_rise;
    else if (ctrl_q.gate) tick_raw = ext_lvl;
    else                  tick_raw = 1'b1;
  end

  dcnt_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(~armed), .bypass(~ctrl_q.presc),
    .tick_in(tick_raw), .tick_out(step_tick)
  );

  dcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(step_tick), .roll(roll_en),
    .preload(pre_val), .count(cnt_val), .armed(armed), .zero_evt(zero_evt)
  );

  assign stat_clr = wr_en && (wr_addr == ADDR_W'(A_STAT)) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zds_q <= 1'b0;
      sq_q  <= 1'b0;
    end else begin
      if (zero_evt)      zds_q <= 1'b1;
      else if (stat_clr) zds_q <= 1'b0;
      if (zero_evt && sq_mode) sq_q <= ~sq_q;
    end
  end

  assign tout = sq_mode ? sq_q : zds_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CTRL)) rd_data = ctrl_q;
    if (rd_addr == ADDR_W'(A_STAT)) rd_data = {7'b0, zds_q};
    for (int i = 0; i < NB; i++) begin
      if (rd_addr == ADDR_W'(A_PRE + NB - 1 - i))    rd_data = pre_q[i];
      if (rd_addr == ADDR_W'(CNT_BASE + NB - 1 - i)) rd_data = cnt_val[8*i +: 8];
    end
  end
endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bit0,
  input logic              run,
  input logic              armed,
  input logic              tick,
  input logic              roll,
  input logic              square,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  preload,
  input logic              zero_evt,
  input logic              zds,
  input logic              tout
);
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(dcnt_pkg::A_CTRL));
  assign stat_wr = wr_en && (wr_addr == ADDR_W'(dcnt_pkg::A_STAT));

  a_r3_load_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !armed) |=> (count == $past(preload)));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed && tick && count != '0) |=> (count == $past(count) - 1'b1));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed && tick && !roll && count == '0) |=> (count == $past(preload)));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed && tick && roll && count == '0) |=> (count == '1));

  a_r12_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> $stable(count));

  a_r6_zero_sets: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> zds);

  a_r6_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_bit0 && !zero_evt) |=> !zds);

  a_r6_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wr_bit0 && zds) |=> zds);

  a_r7_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!square && zero_evt && !ctrl_wr) |=> tout);

  a_r8_square_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (square && zero_evt && !ctrl_wr) |=> (tout != $past(tout)));
endmodule

bind dcnt_timer dcnt_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0]),
  .run(run_en), .armed(armed), .tick(step_tick), .roll(roll_en), .square(sq_mode),
  .count(cnt_val), .preload(pre_val), .zero_evt(zero_evt), .zds(zds_q), .tout(tout)
);

// File: tb/dcnt_timer_tb_top.sv
`timescale 1ns/1ps
module dcnt_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       tout;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    exp_cyc[$];
  string exp_tag[$];
  logic  prev_tout = 1'b0;
  bit    done = 1'b0;

  dcnt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in), .tout(tout)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // expected tout change after clock edge e
  task automatic push_evt(input int e, input string tag);
    exp_cyc.push_back(e);
    exp_tag.push_back(tag);
  endtask

  // called at a falling edge; returns at the falling edge before edge e
  task automatic to_edge(input int e);
    while (cyc < e - 1) @(negedge clk);
  endtask

  task automatic wr_at(input int e, input logic [2:0] a, input logic [7:0] d);
    to_edge(e);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_at(cyc + 1, a, d);
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    rd_addr = a;
    #0.5;
    chk(int'(rd_data), exp, tag);
  endtask

  // scoreboard monitor: every tout change must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && tout !== prev_tout) begin
      total++;
      if (exp_cyc.size() == 0) begin
        bad++;
        $display("FAIL unexpected tout change: got %0b at cycle %0d expected no change", tout, cyc);
      end else begin
        int    e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (e != cyc) begin
          bad++;
          $display("FAIL %s: tout changed at cycle %0d expected cycle %0d", t, cyc, e);
        end
      end
      prev_tout = tout;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t;
    int x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 0, "R1 register reset");
    chk(int'(tout), 0, "R1 tout reset");

    // R2 preload bytes
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h03);
    rd_chk(3'd4, 8'h03, "R2 preload low byte");
    rd_chk(3'd2, 8'h00, "R2 preload high byte");

    // R8 square wave, reload period preload+1 (R4)
    t = cyc + 2;
    for (int k = 0; k < 4; k++) push_evt(t + 4 + 4 * k, "R8 square toggle");
    wr_at(t, 3'd0, 8'h11);
    wr_at(t + 18, 3'd0, 8'h10);
    rd_chk(3'd7, 2, "R4 count after reloads");
    to_edge(cyc + 10);
    rd_chk(3'd7, 2, "R12 halted count holds");
    rd_chk(3'd1, 1, "R6 zero flag set");
    wr(3'd1, 8'h00);
    rd_chk(3'd1, 1, "R6 write zero keeps flag");
    wr(3'd1, 8'h01);
    rd_chk(3'd1, 0, "R6 write one clears flag");
    chk(int'(tout), 0, "R8 tout after four toggles");

    // R5 wrap with interrupt output (R7)
    wr(3'd4, 8'h02);
    t = cyc + 2;
    push_evt(t + 3, "R7 irq rise");
    wr_at(t, 3'd0, 8'h09);
    wr_at(t + 10, 3'd0, 8'h08);
    rd_chk(3'd5, 8'hFF, "R5 wrapped count high");
    rd_chk(3'd6, 8'hFF, "R5 wrapped count mid");
    rd_chk(3'd7, 8'hF9, "R5 wrapped count low");
    x = cyc + 2;
    push_evt(x, "R7 irq falls on clear");
    wr_at(x, 3'd1, 8'h01);
    rd_chk(3'd1, 0, "R6 flag cleared");

    // R6 set beats clear in the same cycle
    t = cyc + 2;
    push_evt(t + 3, "R7 irq rise");
    wr_at(t, 3'd0, 8'h01);
    wr_at(t + 6, 3'd1, 8'h01);
    wr_at(t + 8, 3'd0, 8'h00);
    rd_chk(3'd1, 1, "R6 set wins over clear");
    rd_chk(3'd7, 1, "R4 reload period three ticks");
    x = cyc + 2;
    push_evt(x, "R7 irq falls on clear");
    wr_at(x, 3'd1, 8'h01);

    // R9 divide by 32
    wr(3'd4, 8'h01);
    t = cyc + 2;
    push_evt(t + 33, "R9 prescaled zero");
    wr_at(t, 3'd0, 8'h05);
    to_edge(t + 33);
    rd_chk(3'd1, 0, "R9 no zero before 32 cycles");
    wr_at(t + 40, 3'd0, 8'h04);
    rd_chk(3'd7, 0, "R9 count at zero");
    x = cyc + 2;
    push_evt(x, "R7 irq falls on clear");
    wr_at(x, 3'd1, 8'h01);

    // R11 gate
    wr(3'd4, 8'h05);
    t = cyc + 2;
    wr_at(t, 3'd0, 8'h21);
    to_edge(t + 4);
    rd_chk(3'd7, 5, "R3 preload loaded, gate low");
    to_edge(t + 5); ext_in = 1'b1;
    to_edge(t + 8); ext_in = 1'b0;
    wr_at(t + 15, 3'd0, 8'h20);
    rd_chk(3'd7, 2, "R11 three gated ticks");

    // R10 external clock
    wr(3'd4, 8'h03);
    t = cyc + 2;
    push_evt(t + 14, "R10 external zero");
    wr_at(t, 3'd0, 8'h03);
    for (int p = 0; p < 3; p++) begin
      to_edge(t + 4 + 4 * p); ext_in = 1'b1;
      to_edge(t + 6 + 4 * p); ext_in = 1'b0;
    end
    wr_at(t + 20, 3'd0, 8'h02);
    rd_chk(3'd7, 0, "R10 count after three edges");
    rd_chk(3'd1, 1, "R10 zero flag after three edges");
    to_edge(cyc + 2); ext_in = 1'b1;
    to_edge(cyc + 3); ext_in = 1'b0;
    to_edge(cyc + 6);
    rd_chk(3'd7, 0, "R12 halted ignores external edge");
    x = cyc + 2;
    push_evt(x, "R7 irq falls on clear");
    wr_at(x, 3'd1, 8'h01);

    to_edge(cyc + 5);
    chk(exp_cyc.size(), 0, "R8 all expected tout changes seen");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule